// File: doc/BRIEF.md
# PAM4 Modulo Precoder with Termination Insertion

This transmit-side block takes a stream of 2-bit PAM4 level indices and passes them through a modulo-4 precoder of the form 1/(1+D). The precoder ensures that, once a 1+D channel has combined each symbol with the one before it, the received level is congruent modulo 4 to the original data index. On a fixed grid it also places one known termination symbol into the stream after the precoder. That symbol comes from a PRBS9 generator that the link partner runs in lockstep. Because of it, a receiver running a sequence detector sees a trellis whose state is known at both ends of every block.

Level index a in {0,1,2,3} stands for the line levels {-3,-1,+1,+3}. The output slot that carries the termination symbol does not consume input data. In that cycle the block holds its input ready low, and the data order is preserved. Both sides of the block use a valid/ready handshake, and the path from input to output is combinational, so the block adds no latency.

Top module: `pam4_term_precoder`

## Requirements
- R1: During and directly after synchronous reset, the precoder memory holds index 0, the block counter is 0, and `out_term` is 0. The first output slot after reset is therefore a data slot.
- R2: In a data slot, `out_sym` equals (`in_sym` − m) mod 4, where m is the index of the most recently transferred output symbol. That symbol may be a data symbol or a termination symbol.
- R3: After exactly BLK_LEN data symbols have been transferred since reset or since the last termination, the next output slot is a termination slot with `out_term` = 1. After that slot is transferred, data slots resume.
- R4: The termination index is produced by a PRBS9 register with feedback x^9+x^5+1, seeded with SEED at reset. For each termination, two new bits are shifted in, computed as bit8 XOR bit4 of the current state. The first new bit forms index bit 1 and the second forms index bit 0.
- R5: In a termination slot, `out_valid` is 1 whatever `in_valid` is. In a data slot, `out_valid` equals `in_valid`.
- R6: While a termination slot waits on `out_ready` = 0, the slot stays a termination slot and `out_sym` holds its value. No state advances without a transfer.
- R7: The data indices can be recovered in order from the output as (`out_sym` + m) mod 4, with termination slots skipped. No data symbol is lost or repeated.
- R8: After a termination slot is transferred, the precoder memory equals the termination index. The first data symbol of the next block is precoded against that index.
- R9: In a data slot, `in_ready` equals `out_ready`. In a termination slot, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data index available |
| in_ready | output | 1 | Data index accepted this cycle when in_valid is also high |
| in_sym | input | 2 | Data level index (0..3 maps to -3,-1,+1,+3) |
| out_valid | output | 1 | Output slot holds a symbol |
| out_ready | input | 1 | Downstream takes the slot |
| out_sym | output | 2 | Precoded or termination level index |
| out_term | output | 1 | Slot carries a termination symbol |

## Verification
The hardest condition to reach is a termination slot held under backpressure. It arises only once every BLK_LEN+1 transfers, and only when `out_ready` drops in exactly that cycle. Random stalls alone seldom hit it. The bench therefore tracks its own block count and, in its second phase, forces `out_ready` low for several cycles whenever its model says the next slot is a termination. This also checks that the PRBS does not advance and that the precoder memory is not reloaded until the slot is actually taken. A long run at the default block length also covers many block boundaries, where the precoder memory takes over the termination index.

// File: rtl/pam4_prec_pkg.sv
package pam4_prec_pkg;

    typedef logic [1:0] lvl_t;

    localparam int PRBS_W = 9;

    typedef logic [PRBS_W-1:0] prbs_t;

    typedef struct packed {
        prbs_t state;
        lvl_t  idx;
    } prbs_step_t;

    typedef struct packed {
        lvl_t sym;
        logic term;
    } slot_t;

    // (d - prev) mod 4; the 2-bit wrap does the modulo
    function automatic lvl_t precode(lvl_t d, lvl_t prev);
        return lvl_t'(d - prev);
    endfunction

    // one PRBS9 bit: feedback x^9 + x^5 + 1
    function automatic logic prbs_bit(prbs_t s);
        return s[8] ^ s[4];
    endfunction

    // advance two bits; first bit becomes index MSB
    function automatic prbs_step_t prbs_adv2(prbs_t s);
        prbs_step_t r;
        logic b1, b2;
        prbs_t s1;
        b1 = prbs_bit(s);
        s1 = {s[PRBS_W-2:0], b1};
        b2 = prbs_bit(s1);
        r.state = {s1[PRBS_W-2:0], b2};
        r.idx   = {b1, b2};
        return r;
    endfunction

endpackage

// File: rtl/pam4_blk_counter.sv
module pam4_blk_counter #(
    parameter int BLK_LEN = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_data,
    input  logic adv_term,
    output logic term_slot
);
    localparam int CW = $clog2(BLK_LEN + 1);

    logic [CW-1:0] cnt;

    assign term_slot = (cnt == CW'(BLK_LEN));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv_term)
            cnt <= '0;
        else if (adv_data)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pam4_term_gen.sv
module pam4_term_gen
    import pam4_prec_pkg::*;
#(
    parameter prbs_t SEED = 9'h1FF
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output lvl_t term_idx
);
    prbs_t      state;
    prbs_step_t nxt;

    generate
        if (SEED == '0) begin : g_seed_fix
            localparam prbs_t SEED_USE = prbs_t'(1);
            always_ff @(posedge clk) begin
                if (rst)       state <= SEED_USE;
                else if (step) state <= nxt.state;
            end
        end else begin : g_seed_ok
            always_ff @(posedge clk) begin
                if (rst)       state <= SEED;
                else if (step) state <= nxt.state;
            end
        end
    endgenerate

    always_comb begin
        nxt      = prbs_adv2(state);
        term_idx = nxt.idx;
    end
endmodule

// File: rtl/pam4_mod_precoder.sv
module pam4_mod_precoder
    import pam4_prec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lvl_t d_in,
    input  logic load,
    input  lvl_t load_val,
    output lvl_t p_out
);
    lvl_t mem;

    assign p_out = precode(d_in, mem);

    always_ff @(posedge clk) begin
        if (rst)       mem <= '0;
        else if (load) mem <= load_val;
    end
endmodule

// File: rtl/pam4_term_precoder.sv
module pam4_term_precoder
    import pam4_prec_pkg::*;
#(
    parameter int    BLK_LEN = 255,
    parameter prbs_t SEED    = 9'h1FF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [1:0] in_sym,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [1:0] out_sym,
    output logic       out_term
);
    logic  term_slot;
    logic  xfer;
    lvl_t  term_idx;
    lvl_t  pre_sym;
    slot_t slot;

    assign xfer = out_valid && out_ready;

    pam4_blk_counter #(.BLK_LEN(BLK_LEN)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .adv_data  (xfer && !term_slot),
        .adv_term  (xfer && term_slot),
        .term_slot (term_slot)
    );

    pam4_term_gen #(.SEED(SEED)) u_term (
        .clk      (clk),
        .rst      (rst),
        .step     (xfer && term_slot),
        .term_idx (term_idx)
    );

    pam4_mod_precoder u_prec (
        .clk      (clk),
        .rst      (rst),
        .d_in     (in_sym),
        .load     (xfer),
        .load_val (slot.sym),
        .p_out    (pre_sym)
    );

    always_comb begin
        slot.term = term_slot;
        slot.sym  = term_slot ? term_idx : pre_sym;
    end

    assign out_valid = term_slot ? 1'b1 : in_valid;
    assign in_ready  = term_slot ? 1'b0 : out_ready;
    assign out_sym   = slot.sym;
    assign out_term  = slot.term;
endmodule

// File: rtl/pam4_term_precoder_chk.sv
module pam4_term_precoder_chk #(
    parameter int BLK_LEN = 255
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [1:0] in_sym,
    input logic       out_valid,
    input logic       out_ready,
    input logic [1:0] out_sym,
    input logic       out_term
);
    int         dcnt;
    logic [1:0] last_sent;
    logic       xfer;

    assign xfer = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt      <= 0;
            last_sent <= 2'd0;
        end else if (xfer) begin
            last_sent <= out_sym;
            dcnt      <= out_term ? 0 : dcnt + 1;
        end
    end

    assert_grid_R3: assert property (@(posedge clk) disable iff (rst)
        out_term == (dcnt == BLK_LEN));

    assert_precode_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_term) |-> (2'(out_sym + last_sent) == in_sym));

    assert_term_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_term |-> out_valid);

    assert_data_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !out_term |-> (out_valid == in_valid));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_term && !out_ready) |=> (out_term && $stable(out_sym)));

    assert_ready_R9: assert property (@(posedge clk) disable iff (rst)
        in_ready == (out_ready && !out_term));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> !out_term);
endmodule

bind pam4_term_precoder pam4_term_precoder_chk #(.BLK_LEN(BLK_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sym    (in_sym),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sym   (out_sym),
    .out_term  (out_term)
);

// File: tb/pam4_term_precoder_test.sv
module pam4_term_precoder_test;
    localparam int       BLK = 255;
    localparam bit [8:0] SD  = 9'h1FF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_sym = 2'd0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_sym;
    logic       out_term;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pam4_term_precoder #(.BLK_LEN(BLK), .SEED(SD)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sym(out_sym), .out_term(out_term)
    );

    // reference model state
    int       m_cnt;
    int       m_prev;
    bit [8:0] m_prbs;
    int       sent_q[$];
    int       rx_prev;
    bit       after_term;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_term_idx(bit [8:0] s);
        bit b1, b2;
        b1 = s[8] ^ s[4];
        s  = {s[7:0], b1};
        b2 = s[8] ^ s[4];
        return (b1 ? 2 : 0) + (b2 ? 1 : 0);
    endfunction

    function automatic bit [8:0] model_prbs_next(bit [8:0] s);
        for (int i = 0; i < 2; i++) s = {s[7:0], s[8] ^ s[4]};
        return s;
    endfunction

    task automatic run(input int ncyc, input bool_stall);
        int  stall_left;
        bit  hold;
        stall_left = 3;
        hold = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (!hold) begin
                in_valid = ($urandom_range(0, 99) < 85);
                in_sym   = 2'($urandom_range(0, 3));
            end
            out_ready = ($urandom_range(0, 99) < 80);
            if (bool_stall && m_cnt == BLK && stall_left > 0) begin
                out_ready = 1'b0;
                stall_left--;
            end
            #1;
            begin
                bit eterm, evalid, eready;
                int esym, rec;
                eterm  = (m_cnt == BLK);
                evalid = eterm ? 1'b1 : in_valid;
                eready = eterm ? 1'b0 : out_ready;
                esym   = eterm ? model_term_idx(m_prbs) : ((int'(in_sym) - m_prev + 4) % 4);
                chk(out_term == eterm, "R3 term slot", out_term, eterm);
                chk(out_valid == evalid, "R5 out_valid", out_valid, evalid);
                chk(in_ready == eready, "R9 in_ready", in_ready, eready);
                if (evalid) begin
                    if (eterm && !out_ready)
                        chk(out_sym == esym, "R6 held term symbol", out_sym, esym);
                    else if (eterm)
                        chk(out_sym == esym, "R4 term index", out_sym, esym);
                    else if (after_term)
                        chk(out_sym == esym, "R8 first symbol after term", out_sym, esym);
                    else
                        chk(out_sym == esym, "R2 precoded symbol", out_sym, esym);
                end
                if (in_valid && in_ready) sent_q.push_back(int'(in_sym));
                if (out_valid && out_ready) begin
                    if (!out_term) begin
                        rec = (int'(out_sym) + rx_prev) % 4;
                        if (sent_q.size() == 0)
                            chk(0, "R7 data order (empty)", rec, -1);
                        else
                            chk(rec == sent_q.pop_front(), "R7 data order", rec, rec);
                    end
                    rx_prev = int'(out_sym);
                end
                // model update on transfer
                if (evalid && out_ready) begin
                    if (eterm) begin
                        m_prev     = esym;
                        m_prbs     = model_prbs_next(m_prbs);
                        m_cnt      = 0;
                        after_term = 1;
                        stall_left = 3;
                    end else begin
                        m_prev     = esym;
                        m_cnt++;
                        after_term = 0;
                    end
                end
                hold = in_valid && !in_ready;
            end
        end
    endtask

    initial begin
        m_cnt = 0; m_prev = 0; m_prbs = SD; rx_prev = 0; after_term = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk(out_term == 1'b0, "R1 reset term flag", out_term, 0);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b1; in_sym = 2'd3; out_ready = 1'b1;
        #1;
        chk(out_sym == 2'd3, "R1 first symbol precoded against 0", out_sym, 3);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        in_valid = 1'b0; out_ready = 1'b0;
        run(1200, 1'b0);
        run(2500, 1'b1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule